// File: doc/BRIEF.md
# Packet Status and Interrupt Selector

This block sits behind a receive-side signal monitor that produces two detector flags: one that says a carrier is present and one that says the received waveform has settled at its midpoint, which usually means a packet has ended. A two-bit mode taken from the host's command bits picks how these flags become a single packet-status bit and when that bit raises a sticky interrupt flag for the host.

Whenever either mode bit is set, the block also puts the two raw detector flags into the two low bits of the data-quality value the host reads. The carrier flag goes to bit 0 and the end flag goes to bit 1. This override stays latched after the mode returns to off. It is released only by one of three restore events: a reset command, a switch to transmit, or entry to power save. When released, the unmodified quality value shows through again.

Top module: `pkt_status_irq`

## Requirements
- R1: With mode 00 (both command bits 0), status_o is 0 and no interrupt is raised, whatever the detectors do.
- R2: With mode 01 (cmd_env_i=1, cmd_eop_i=0), status_o equals env_i. A 0-to-1 change of status_o raises irq_o on the next clock edge.
- R3: With mode 10 (cmd_env_i=0, cmd_eop_i=1), status_o equals eop_i. A 0-to-1 change of status_o raises irq_o on the next clock edge.
- R4: With mode 11, status_o equals env_i AND NOT eop_i. Both rising and falling changes of status_o raise irq_o on the next clock edge.
- R5: While either command bit is 1, dq_o[0] equals env_i and dq_o[1] equals eop_i. dq_o bits above 1 always equal dq_i.
- R6: Once the override has been entered, it stays in force after the mode returns to 00. In mode 00 no interrupt is raised.
- R7: In mode 00, a pulse on any of rst_cmd_i, tx_sel_i or psave_i ends the override, so that from the following cycle dq_o equals dq_i.
- R8: An interrupt event sets irq_o only when irq_en_i is 1 in the cycle of the event.
- R9: irq_o stays 1 until a cycle with irq_clr_i=1, after which it reads 0.
- R10: If irq_clr_i and an enabled interrupt event occur in the same cycle, irq_o remains 1.
- R11: The cycle in which the mode changes raises no interrupt, even if status_o changes in that cycle.
- R12: After rst_n is released, irq_o is 0, the override is off (dq_o equals dq_i in mode 00) and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Carrier-present detector flag |
| eop_i | input | 1 | End-of-packet detector flag |
| cmd_env_i | input | 1 | Command bit selecting the carrier detector (mode bit 0) |
| cmd_eop_i | input | 1 | Command bit selecting the end detector (mode bit 1) |
| dq_i | input | DQ_W | Measured data-quality value |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Host clear pulse for the interrupt flag |
| rst_cmd_i | input | 1 | Reset-command restore event |
| tx_sel_i | input | 1 | Transmit-select restore event |
| psave_i | input | 1 | Power-save entry restore event |
| status_o | output | 1 | Packet status bit |
| irq_o | output | 1 | Sticky interrupt flag |
| dq_o | output | DQ_W | Data-quality value with optional low-bit override |

## Verification
The assertions check several properties on every cycle. The interrupt flag only drops after a clear. It only rises with the enable set. It never rises in mode 00 or in a cycle where the mode changes. The override latch holds until a restore event. Mode 00 forces the status low. The edge rules for each mode have to be shown by the bench's scenarios: a single rising edge in the two single-detector modes, both edges in the combined mode, and the clear-versus-event collision. The same goes for the persistence of the override after leaving the modes and its release by each of the three restore events.

// File: rtl/pkt_status_pkg.sv
package pkt_status_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ENV  = 2'b01,
    MODE_EOP  = 2'b10,
    MODE_BOTH = 2'b11
  } psel_mode_t;

  localparam int unsigned OVR_BITS = 2;

endpackage

// File: rtl/pkt_stat_sel.sv
module pkt_stat_sel
  import pkt_status_pkg::*;
(
  input  psel_mode_t mode_i,
  input  logic       env_i,
  input  logic       eop_i,
  output logic       status_o
);

  always_comb begin
    unique case (mode_i)
      MODE_OFF:  status_o = 1'b0;
      MODE_ENV:  status_o = env_i;
      MODE_EOP:  status_o = eop_i;
      MODE_BOTH: status_o = env_i & ~eop_i;
      default:   status_o = 1'b0;
    endcase
  end

  // R1
  always_comb begin
    if (mode_i == MODE_OFF) begin
      off_mode_quiet_chk: assert (status_o == 1'b0);
    end
  end

endmodule

// File: rtl/pkt_irq_edge.sv
module pkt_irq_edge
  import pkt_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  psel_mode_t mode_i,
  input  logic       status_i,
  input  logic       irq_en_i,
  input  logic       irq_clr_i,
  output logic       irq_o
);

  psel_mode_t mode_q, mode_d;
  logic       stat_q, stat_d;
  logic       irq_q,  irq_d;
  logic       same_mode;
  logic       edge_hit;

  assign same_mode = (mode_i == mode_q);

  always_comb begin
    edge_hit = 1'b0;
    unique case (mode_i)
      MODE_ENV,
      MODE_EOP:  edge_hit = status_i & ~stat_q;
      MODE_BOTH: edge_hit = status_i ^ stat_q;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    mode_d = mode_i;
    stat_d = status_i;
    irq_d  = irq_q;
    if (same_mode && edge_hit && irq_en_i) begin
      irq_d = 1'b1;
    end else if (irq_clr_i) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr_i |=> irq_q);

  // R8
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !irq_en_i |=> !irq_q);

  // R11
  no_irq_on_mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && (mode_i != mode_q) |=> !irq_q);

  // R6
  no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && (mode_i == MODE_OFF) |=> !irq_q);

  // R10
  clr_loses_to_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i && irq_en_i && same_mode && (mode_i == MODE_BOTH) && (status_i != stat_q)
    |=> irq_q);

endmodule

// File: rtl/pkt_dq_ovr.sv
module pkt_dq_ovr
  import pkt_status_pkg::*;
#(
  parameter int unsigned DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  psel_mode_t      mode_i,
  input  logic            env_i,
  input  logic            eop_i,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            restore_i,
  output logic [DQ_W-1:0] dq_o
);

  localparam int unsigned HI_W = DQ_W - OVR_BITS;

  logic                ovr_q, ovr_d;
  logic                ovr_show;
  logic [OVR_BITS-1:0] raw_flags;

  assign raw_flags = {eop_i, env_i};

  always_comb begin
    ovr_d = ovr_q;
    if (restore_i) begin
      ovr_d = 1'b0;
    end else if (mode_i != MODE_OFF) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  assign ovr_show = ovr_q | (mode_i != MODE_OFF);

  for (genvar b = 0; b < OVR_BITS; b++) begin : g_low
    assign dq_o[b] = ovr_show ? raw_flags[b] : dq_i[b];
  end

  if (HI_W > 0) begin : g_high
    assign dq_o[DQ_W-1:OVR_BITS] = dq_i[DQ_W-1:OVR_BITS];
  end

  // R6
  ovr_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !restore_i |=> ovr_q);

  // R7
  ovr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> !ovr_q);

endmodule

// File: rtl/pkt_status_irq.sv
module pkt_status_irq
  import pkt_status_pkg::*;
#(
  parameter int unsigned DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            env_i,
  input  logic            eop_i,
  input  logic            cmd_env_i,
  input  logic            cmd_eop_i,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            irq_en_i,
  input  logic            irq_clr_i,
  input  logic            rst_cmd_i,
  input  logic            tx_sel_i,
  input  logic            psave_i,
  output logic            status_o,
  output logic            irq_o,
  output logic [DQ_W-1:0] dq_o
);

  psel_mode_t mode;
  logic       status;
  logic       restore;

  assign mode    = psel_mode_t'({cmd_eop_i, cmd_env_i});
  assign restore = rst_cmd_i | tx_sel_i | psave_i;

  pkt_stat_sel u_sel (
    .mode_i   (mode),
    .env_i    (env_i),
    .eop_i    (eop_i),
    .status_o (status)
  );

  pkt_irq_edge u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .status_i  (status),
    .irq_en_i  (irq_en_i),
    .irq_clr_i (irq_clr_i),
    .irq_o     (irq_o)
  );

  pkt_dq_ovr #(.DQ_W(DQ_W)) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .env_i     (env_i),
    .eop_i     (eop_i),
    .dq_i      (dq_i),
    .restore_i (restore),
    .dq_o      (dq_o)
  );

  assign status_o = status;

endmodule

// File: tb/pkt_status_irq_test.sv
module pkt_status_irq_test;

  localparam int DQ_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            env_i = 1'b0, eop_i = 1'b0;
  logic            cmd_env_i = 1'b0, cmd_eop_i = 1'b0;
  logic [DQ_W-1:0] dq_i = '0;
  logic            irq_en_i = 1'b0, irq_clr_i = 1'b0;
  logic            rst_cmd_i = 1'b0, tx_sel_i = 1'b0, psave_i = 1'b0;
  logic            status_o, irq_o;
  logic [DQ_W-1:0] dq_o;

  always #2 clk = ~clk;

  pkt_status_irq #(.DQ_W(DQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .env_i(env_i), .eop_i(eop_i),
    .cmd_env_i(cmd_env_i), .cmd_eop_i(cmd_eop_i), .dq_i(dq_i),
    .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i), .rst_cmd_i(rst_cmd_i),
    .tx_sel_i(tx_sel_i), .psave_i(psave_i),
    .status_o(status_o), .irq_o(irq_o), .dq_o(dq_o)
  );

  typedef struct {
    logic            st;
    logic            irq;
    logic [DQ_W-1:0] dq;
    string           tag;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // requirement-level model state
  logic [1:0] m_mode = 2'b00;
  logic       m_stat = 1'b0;
  logic       m_irq  = 1'b0;
  logic       m_ovr  = 1'b0;

  function automatic logic sel_status(logic [1:0] md, logic e, logic p);
    case (md)
      2'b01:   return e;
      2'b10:   return p;
      2'b11:   return e & ~p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic [1:0] md, input logic e, input logic p,
                      input logic en, input logic clr, input logic rc,
                      input logic tx, input logic ps, input logic [DQ_W-1:0] dq,
                      input string tag);
    exp_t x;
    logic st, ev;
    @(negedge clk);
    {cmd_eop_i, cmd_env_i} = md;
    env_i = e; eop_i = p; irq_en_i = en; irq_clr_i = clr;
    rst_cmd_i = rc; tx_sel_i = tx; psave_i = ps; dq_i = dq;
    st = sel_status(md, e, p);
    ev = 1'b0;
    if (md == m_mode) begin
      if ((md == 2'b01 || md == 2'b10) && st && !m_stat) ev = 1'b1;
      if (md == 2'b11 && st != m_stat) ev = 1'b1;
    end
    if (ev && en) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    if (rc || tx || ps) m_ovr = 1'b0;
    else if (md != 2'b00) m_ovr = 1'b1;
    m_mode = md;
    m_stat = st;
    x.st  = st;
    x.irq = m_irq;
    x.dq  = (md != 2'b00 || m_ovr) ? {dq[DQ_W-1:2], p, e} : dq;
    x.tag = tag;
    sb_q.push_back(x);
  endtask

  // monitor: compares one expected item per clock, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        n_cmp++;
        if (status_o !== x.st || irq_o !== x.irq || dq_o !== x.dq) begin
          n_bad++;
          $display("FAIL %s: got st=%0b irq=%0b dq=%02h, expected st=%0b irq=%0b dq=%02h",
                   x.tag, status_o, irq_o, dq_o, x.st, x.irq, x.dq);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    step(2'b00, 0, 0, 1, 0, 0, 0, 0, 8'h5A, "R12");
    // R1: detectors toggle in mode 00
    step(2'b00, 1, 0, 1, 0, 0, 0, 0, 8'h5A, "R1");
    step(2'b00, 0, 1, 1, 0, 0, 0, 0, 8'h5B, "R1");
    step(2'b00, 1, 1, 1, 0, 0, 0, 0, 8'h5B, "R1");
    // R11: enter mode 01 with env already high, no interrupt
    step(2'b01, 1, 0, 1, 0, 0, 0, 0, 8'hA6, "R11");
    step(2'b01, 0, 0, 1, 0, 0, 0, 0, 8'hA6, "R2");
    // R2 / R5: rising edge raises irq; low bits mirror
    step(2'b01, 1, 0, 1, 0, 0, 0, 0, 8'hA6, "R2");
    step(2'b01, 1, 1, 1, 0, 0, 0, 0, 8'hA7, "R5");
    // R9: flag holds, then clear
    step(2'b01, 0, 1, 1, 0, 0, 0, 0, 8'hA7, "R9");
    step(2'b01, 0, 1, 1, 1, 0, 0, 0, 8'hA7, "R9");
    // R8: disabled rising edge leaves flag low
    step(2'b01, 1, 0, 0, 0, 0, 0, 0, 8'hA7, "R8");
    step(2'b01, 1, 0, 1, 0, 0, 0, 0, 8'hA7, "R8");
    // R3: end-detector mode
    step(2'b10, 0, 0, 1, 0, 0, 0, 0, 8'h30, "R11");
    step(2'b10, 1, 1, 1, 0, 0, 0, 0, 8'h30, "R3");
    step(2'b10, 1, 0, 1, 1, 0, 0, 0, 8'h30, "R3");
    step(2'b10, 0, 0, 1, 0, 0, 0, 0, 8'h30, "R3");
    // R4: combined mode, both edges
    step(2'b11, 0, 0, 1, 0, 0, 0, 0, 8'hC3, "R11");
    step(2'b11, 1, 0, 1, 0, 0, 0, 0, 8'hC3, "R4");
    step(2'b11, 1, 0, 1, 1, 0, 0, 0, 8'hC3, "R4");
    step(2'b11, 1, 1, 1, 0, 0, 0, 0, 8'hC3, "R4");
    step(2'b11, 0, 1, 1, 1, 0, 0, 0, 8'hC3, "R4");
    // R10: clear coinciding with an event
    step(2'b11, 1, 0, 1, 1, 0, 0, 0, 8'hC3, "R10");
    step(2'b11, 1, 0, 1, 1, 0, 0, 0, 8'hC3, "R9");
    // R6: back to mode 00, override persists, no irq
    step(2'b00, 1, 0, 1, 0, 0, 0, 0, 8'hF0, "R6");
    step(2'b00, 0, 1, 1, 0, 0, 0, 0, 8'hF0, "R6");
    step(2'b00, 1, 1, 1, 0, 0, 0, 0, 8'hF0, "R6");
    // R7: each restore event in turn
    step(2'b00, 1, 1, 1, 0, 1, 0, 0, 8'hF0, "R7");
    step(2'b00, 1, 1, 1, 0, 0, 0, 0, 8'hF0, "R7");
    step(2'b01, 0, 1, 1, 0, 0, 0, 0, 8'h0F, "R5");
    step(2'b00, 0, 1, 1, 0, 0, 0, 0, 8'h0F, "R6");
    step(2'b00, 0, 1, 1, 0, 0, 1, 0, 8'h0F, "R7");
    step(2'b00, 1, 0, 1, 0, 0, 0, 0, 8'h0C, "R7");
    step(2'b10, 1, 0, 1, 0, 0, 0, 0, 8'h0C, "R5");
    step(2'b00, 1, 0, 1, 0, 0, 0, 0, 8'h0C, "R6");
    step(2'b00, 1, 0, 1, 0, 0, 0, 1, 8'h0C, "R7");
    step(2'b00, 0, 1, 1, 0, 0, 0, 0, 8'h0E, "R7");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule